// File: doc/BRIEF.md
# T1 Alarm Status LED Controller

This block turns the alarm status of a T1/E1 line framer into link state, front-panel LED drives and alarm event pulses. Software or a sequencer reads the framer's two alarm status words and presents them on the inputs. A one-cycle poll strobe marks the cycle in which those words are valid. On that strobe the block works out whether the link is usable. It sets the blue, yellow, red and green LEDs and keeps registered copies of both words for later readout.

Four conditions are monitored. They are receive AIS (blue alarm), multiframe yellow alarm, loss of frame and loss of signal. Each condition has its own last-state flag. When a condition becomes active or clears at a poll, the block emits a one-cycle start or end pulse on that condition's lane. The in-channel yellow indication is deliberately ignored, because payload data patterns can imitate it. Loss of frame and loss of signal drive one shared red LED. That LED stays lit while either cause is present.

Top module: `t1_alarm_led_ctrl`

## Requirements
- R1: While and directly after reset, with no poll yet seen, link_up, every LED output, every event lane and both status copies read 0.
- R2: A poll with bit 0 of alarm_word1 (receive AIS) set lights led_blue and forces link_up to 0; a poll with it clear turns led_blue off.
- R3: A poll with bit 1 of alarm_word1 (multiframe yellow) set lights led_yellow and forces link_up to 0. Bit 2 (in-channel yellow) and bits 5 to 7 have no effect on link_up, the LEDs or the event lanes.
- R4: A poll with bit 3 (loss of frame) or bit 4 (loss of signal) of alarm_word1 set lights led_red and forces link_up to 0.
- R5: When one red cause clears at a poll, led_red stays lit if the other cause is still set. It turns off only at a poll where both are clear.
- R6: The event lanes are indexed 0 = AIS, 1 = multiframe yellow, 2 = loss of frame, 3 = loss of signal. Loss of frame and loss of signal raise their start and end pulses on their own lanes, independently of each other.
- R7: A start pulse on a lane is raised when its condition is set at a poll and was clear at the previous poll. An end pulse is raised in the reverse case. Each pulse is high for exactly the one cycle after the poll edge.
- R8: led_green is 1 from the first poll after reset onwards.
- R9: At every poll, stat1_q and stat2_q take the full values of alarm_word1 and alarm_word2. They keep those values until the next poll.
- R10: After a poll, link_up is 1 exactly when none of the four monitored conditions was set at that poll.
- R11: In cycles without a poll, changes on the alarm words leave all outputs unchanged, and no event pulses are raised.
- R12: All last-state flags are clear after reset, so the first poll with a monitored condition active raises that condition's start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll | input | 1 | One-cycle strobe: alarm words are valid |
| alarm_word1 | input | STAT1_W | First framer alarm status word |
| alarm_word2 | input | STAT2_W | Second framer alarm status word |
| link_up | output | 1 | Link usable at last poll |
| led_blue | output | 1 | Receive AIS LED |
| led_yellow | output | 1 | Multiframe yellow LED |
| led_red | output | 1 | Loss of frame or loss of signal LED |
| led_green | output | 1 | Adapter active LED |
| start_evt | output | 4 | Per-condition alarm start pulses |
| end_evt | output | 4 | Per-condition alarm end pulses |
| stat1_q | output | STAT1_W | Latched copy of alarm_word1 |
| stat2_q | output | STAT2_W | Latched copy of alarm_word2 |

## Verification
Every output passes through one register. The link state, the LEDs, the status copies and the event pulses are therefore all due in the cycle after the clock edge that samples the poll. The event pulses must be gone one cycle after that. The bench drives the words and the strobe on the falling edge. It checks the full output set on the falling edge right after the sampling edge, and then checks again one cycle later that the events have dropped while the other outputs hold. For the no-poll cases, the bench changes the words without a strobe and checks that every output is unchanged after two more edges.

// File: rtl/t1al_pkg.sv
package t1al_pkg;
  localparam int NUM_ALARMS = 4;
  localparam int IDX_AIS    = 0;
  localparam int IDX_MYEL   = 1;
  localparam int IDX_LOF    = 2;
  localparam int IDX_LOS    = 3;
endpackage

// File: rtl/t1al_alarm_track.sv
module t1al_alarm_track (
  input  logic clk,
  input  logic rst,
  input  logic poll,
  input  logic active,
  output logic flag,
  output logic start_p,
  output logic end_p
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag    <= 1'b0;
      start_p <= 1'b0;
      end_p   <= 1'b0;
    end else begin
      start_p <= 1'b0;
      end_p   <= 1'b0;
      if (poll) begin
        flag    <= active;
        start_p <= active & ~flag;
        end_p   <= ~active & flag;
      end
    end
  end
endmodule

// File: rtl/t1al_led_drv.sv
module t1al_led_drv
  import t1al_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  poll,
  input  logic [NUM_ALARMS-1:0] act,
  output logic                  link_up,
  output logic                  led_blue,
  output logic                  led_yellow,
  output logic                  led_red,
  output logic                  led_green
);
  logic red_cause;
  assign red_cause = act[IDX_LOF] | act[IDX_LOS];

  always_ff @(posedge clk) begin
    if (rst) begin
      link_up    <= 1'b0;
      led_blue   <= 1'b0;
      led_yellow <= 1'b0;
      led_red    <= 1'b0;
      led_green  <= 1'b0;
    end else if (poll) begin
      link_up    <= ~(|act);
      led_blue   <= act[IDX_AIS];
      led_yellow <= act[IDX_MYEL];
      led_green  <= 1'b1;
      if (red_cause) led_red <= 1'b1;
      else           led_red <= 1'b0;
    end
  end
endmodule

// File: rtl/t1al_status_latch.sv
module t1al_status_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         poll,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (poll) q <= d;
  end
endmodule

// File: rtl/t1_alarm_led_ctrl.sv
module t1_alarm_led_ctrl
  import t1al_pkg::*;
#(
  parameter int STAT1_W  = 8,
  parameter int STAT2_W  = 8,
  parameter int BIT_AIS  = 0,
  parameter int BIT_MYEL = 1,
  parameter int BIT_LOF  = 3,
  parameter int BIT_LOS  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  poll,
  input  logic [STAT1_W-1:0]    alarm_word1,
  input  logic [STAT2_W-1:0]    alarm_word2,
  output logic                  link_up,
  output logic                  led_blue,
  output logic                  led_yellow,
  output logic                  led_red,
  output logic                  led_green,
  output logic [NUM_ALARMS-1:0] start_evt,
  output logic [NUM_ALARMS-1:0] end_evt,
  output logic [STAT1_W-1:0]    stat1_q,
  output logic [STAT2_W-1:0]    stat2_q
);
  logic [NUM_ALARMS-1:0] act;
  logic [NUM_ALARMS-1:0] flags;

  assign act[IDX_AIS]  = alarm_word1[BIT_AIS];
  assign act[IDX_MYEL] = alarm_word1[BIT_MYEL];
  assign act[IDX_LOF]  = alarm_word1[BIT_LOF];
  assign act[IDX_LOS]  = alarm_word1[BIT_LOS];

  for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_track
    t1al_alarm_track u_trk (
      .clk     (clk),
      .rst     (rst),
      .poll    (poll),
      .active  (act[i]),
      .flag    (flags[i]),
      .start_p (start_evt[i]),
      .end_p   (end_evt[i])
    );
  end

  t1al_led_drv u_led (
    .clk        (clk),
    .rst        (rst),
    .poll       (poll),
    .act        (act),
    .link_up    (link_up),
    .led_blue   (led_blue),
    .led_yellow (led_yellow),
    .led_red    (led_red),
    .led_green  (led_green)
  );

  t1al_status_latch #(.W(STAT1_W)) u_st1 (
    .clk (clk), .rst (rst), .poll (poll), .d (alarm_word1), .q (stat1_q)
  );

  t1al_status_latch #(.W(STAT2_W)) u_st2 (
    .clk (clk), .rst (rst), .poll (poll), .d (alarm_word2), .q (stat2_q)
  );

  logic unused_flags;
  assign unused_flags = ^flags;
endmodule

// File: rtl/t1al_checker.sv
module t1al_checker
  import t1al_pkg::*;
#(
  parameter int STAT1_W  = 8,
  parameter int STAT2_W  = 8,
  parameter int BIT_AIS  = 0,
  parameter int BIT_MYEL = 1,
  parameter int BIT_LOF  = 3,
  parameter int BIT_LOS  = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  poll,
  input logic [STAT1_W-1:0]    alarm_word1,
  input logic [STAT2_W-1:0]    alarm_word2,
  input logic                  link_up,
  input logic                  led_blue,
  input logic                  led_yellow,
  input logic                  led_red,
  input logic                  led_green,
  input logic [NUM_ALARMS-1:0] start_evt,
  input logic [NUM_ALARMS-1:0] end_evt,
  input logic [STAT1_W-1:0]    stat1_q,
  input logic [STAT2_W-1:0]    stat2_q
);
  assert_blue_follows_R2: assert property (@(posedge clk) disable iff (rst)
    poll |=> (led_blue == $past(alarm_word1[BIT_AIS])));

  assert_yellow_follows_R3: assert property (@(posedge clk) disable iff (rst)
    poll |=> (led_yellow == $past(alarm_word1[BIT_MYEL])));

  assert_red_either_R5: assert property (@(posedge clk) disable iff (rst)
    poll |=> (led_red == ($past(alarm_word1[BIT_LOF]) || $past(alarm_word1[BIT_LOS]))));

  assert_evt_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    ((start_evt & end_evt) == '0));

  assert_evt_after_poll_R7: assert property (@(posedge clk) disable iff (rst)
    ((|start_evt) || (|end_evt)) |-> $past(poll));

  assert_green_on_R8: assert property (@(posedge clk) disable iff (rst)
    poll |=> led_green);

  assert_link_clean_R10: assert property (@(posedge clk) disable iff (rst)
    link_up |-> !(led_blue || led_yellow || led_red));

  assert_hold_no_poll_R11: assert property (@(posedge clk) disable iff (rst)
    !poll |=> ($stable(stat1_q) && $stable(stat2_q) && $stable(link_up)
               && $stable(led_red) && start_evt == '0 && end_evt == '0));

  logic unused_w2;
  assign unused_w2 = ^alarm_word2;
endmodule

bind t1_alarm_led_ctrl t1al_checker #(
  .STAT1_W(STAT1_W), .STAT2_W(STAT2_W), .BIT_AIS(BIT_AIS),
  .BIT_MYEL(BIT_MYEL), .BIT_LOF(BIT_LOF), .BIT_LOS(BIT_LOS)
) u_chk (.*);

// File: tb/sim_t1_alarm_led_ctrl.sv
`timescale 1ns/1ps
module sim_t1_alarm_led_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       poll = 1'b0;
  logic [7:0] w1 = '0;
  logic [7:0] w2 = '0;
  logic       link_up, led_blue, led_yellow, led_red, led_green;
  logic [3:0] start_evt, end_evt;
  logic [7:0] stat1_q, stat2_q;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [3:0] m_flag = '0;
  logic [3:0] m_start = '0, m_end = '0;
  logic       m_link = 0, m_blue = 0, m_yel = 0, m_red = 0, m_green = 0;
  logic [7:0] m_s1 = '0, m_s2 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  t1_alarm_led_ctrl u0 (
    .clk(clk), .rst(rst), .poll(poll), .alarm_word1(w1), .alarm_word2(w2),
    .link_up(link_up), .led_blue(led_blue), .led_yellow(led_yellow),
    .led_red(led_red), .led_green(led_green), .start_evt(start_evt),
    .end_evt(end_evt), .stat1_q(stat1_q), .stat2_q(stat2_q)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(string ctx);
    chk({"R10 link_up ", ctx}, {31'b0, link_up}, {31'b0, m_link});
    chk({"R2 led_blue ", ctx}, {31'b0, led_blue}, {31'b0, m_blue});
    chk({"R3 led_yellow ", ctx}, {31'b0, led_yellow}, {31'b0, m_yel});
    chk({"R4 led_red ", ctx}, {31'b0, led_red}, {31'b0, m_red});
    chk({"R8 led_green ", ctx}, {31'b0, led_green}, {31'b0, m_green});
    chk({"R7 start_evt ", ctx}, {28'b0, start_evt}, {28'b0, m_start});
    chk({"R7 end_evt ", ctx}, {28'b0, end_evt}, {28'b0, m_end});
    chk({"R9 stat1_q ", ctx}, {24'b0, stat1_q}, {24'b0, m_s1});
    chk({"R9 stat2_q ", ctx}, {24'b0, stat2_q}, {24'b0, m_s2});
  endtask

  // Poll once and check results on the cycle after the edge, then check
  // that the event pulses have dropped one cycle later.
  task automatic do_poll(logic [7:0] a, logic [7:0] b, string ctx);
    logic [3:0] act;
    @(negedge clk);
    w1 = a; w2 = b; poll = 1'b1;
    act = {a[4], a[3], a[1], a[0]};
    m_start = act & ~m_flag;
    m_end   = ~act & m_flag;
    m_flag  = act;
    m_link  = (act == 4'b0);
    m_blue  = act[0];
    m_yel   = act[1];
    m_red   = act[2] | act[3];
    m_green = 1'b1;
    m_s1 = a; m_s2 = b;
    @(negedge clk);
    poll = 1'b0;
    chk_all(ctx);
    @(negedge clk);
    m_start = '0; m_end = '0;
    chk_all({ctx, " +1"});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk_all("R1 reset");
    rst = 1'b0;
    @(negedge clk);
    chk_all("R1 after reset");
  endtask

  task automatic t_blue;
    do_poll(8'h01, 8'h00, "R12 first AIS start");
    do_poll(8'h01, 8'h00, "R2 AIS held no new event");
    do_poll(8'h00, 8'h00, "R2 AIS end");
  endtask

  task automatic t_ignored_yellow;
    do_poll(8'hE4, 8'h00, "R3 in-channel yellow ignored");
    chk("R3 link stays up", {31'b0, link_up}, 32'd1);
    do_poll(8'h02, 8'h00, "R3 multiframe yellow");
    do_poll(8'h00, 8'h00, "R3 yellow end");
  endtask

  task automatic t_red;
    do_poll(8'h08, 8'h00, "R4 LOF start");
    do_poll(8'h18, 8'h00, "R6 LOS start own lane");
    do_poll(8'h10, 8'h00, "R5 LOF ends red stays");
    chk("R5 red kept by LOS", {31'b0, led_red}, 32'd1);
    do_poll(8'h00, 8'h00, "R5 both clear red off");
    chk("R5 red off", {31'b0, led_red}, 32'd0);
    do_poll(8'h10, 8'h00, "R4 LOS alone");
    do_poll(8'h08, 8'h00, "R6 swap LOS to LOF");
    do_poll(8'h00, 8'h00, "R6 LOF end");
  endtask

  task automatic t_no_poll;
    @(negedge clk);
    w1 = 8'h1B; w2 = 8'hA5;
    @(negedge clk);
    @(negedge clk);
    chk_all("R11 no poll");
  endtask

  task automatic t_words;
    do_poll(8'h5A, 8'hC3, "R9 words latched");
    do_poll(8'h1F, 8'h3C, "R10 all alarms");
    do_poll(8'h00, 8'hFF, "R10 clear");
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_blue();
    t_ignored_yellow();
    t_red();
    t_no_poll();
    t_words();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end
endmodule